// File: doc/BRIEF.md
# Frame Byte Count Limit Monitor

This block watches the bytes of one frame as it moves through a transmit or receive path. It keeps a running count and compares it with a 12-bit limit that software programs. When the count reaches the limit, the block raises an interrupt request for the active direction, provided that direction's interrupt is enabled. The count begins with the first byte after the start-of-frame delimiter. On transmit, the CRC bytes appended at the end of the frame are left out of the count. Reaching the limit only produces a signal. The block never stalls, drops or reshapes frame or FIFO traffic.

The byte strobe is a one-way notification and has no ready signal. The monitor accepts a strobe in every cycle and never applies back-pressure. All other pins are plain control and status levels or pulses. A simple write port sets the limit's low byte, its high nibble and the two enable bits. One limit value serves whichever direction is active.

Top module: `frame_count_monitor`

## Requirements
- R1: After reset `byte_count` is 0, both interrupt lines are low, the limit is 0 and both interrupts are disabled.
- R2: A write to address 0 sets limit bits 7:0. A write to address 1 sets limit bits 11:8 from data bits 3:0, and data bits 7:4 are ignored. A write to address 2 sets the transmit enable from data bit 0 and the receive enable from data bit 1, where 1 means enabled. Every write takes effect from the next cycle.
- R3: A cycle with `sfd_seen` high clears `byte_count` to 0 in the next cycle. A strobe in that same cycle is not counted, and strobes before the first delimiter after reset are not counted.
- R4: Within a frame, each counted `byte_stb` raises `byte_count` by 1, and the new value is visible in the cycle after the strobe.
- R5: When `dir_tx` is 1 and `tx_crc_phase` is 1, strobes are not counted. When `dir_tx` is 0, strobes are counted whatever the value of `tx_crc_phase`.
- R6: `byte_count` saturates at 4095 and never wraps.
- R7: In the cycle after the counted byte that makes the count equal the limit, `irq_tx` pulses high for one cycle if `dir_tx` is 1 and the transmit enable is set. `irq_rx` pulses in the same way if `dir_tx` is 0 and the receive enable is set. The two lines are never high together.
- R8: The limit is matched at most once per frame. A match that happens while the interrupt is disabled still uses up that frame's match, and the next delimiter re-arms it.
- R9: A limit of 0 never raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 limit low, 1 limit high, 2 enables |
| reg_wr_data | input | 8 | Register write data |
| sfd_seen | input | 1 | Start-of-frame delimiter detected, one-cycle pulse |
| byte_stb | input | 1 | One frame byte passed in this cycle |
| tx_crc_phase | input | 1 | Transmit path is sending appended CRC bytes |
| dir_tx | input | 1 | 1 = transmit active, 0 = receive active |
| byte_count | output | 12 | Running count of counted bytes in the frame |
| irq_tx | output | 1 | Transmit limit-reached interrupt pulse |
| irq_rx | output | 1 | Receive limit-reached interrupt pulse |

## Verification
A stuck or mis-cleared counter shows on `byte_count` one cycle after the offending strobe or delimiter. The bench therefore compares the count after every byte it sends. A wrong match-used flag shows as an interrupt that is missing on the limit byte, or as an extra one after it. These appear within a cycle of that byte, either in a later frame that is re-armed or once the interrupt is enabled late. A corrupted limit or enable register shows only when the limit byte arrives, so limits are chosen to use both the low and high parts of the limit.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;

  typedef enum logic [1:0] {
    ADDR_LIMIT_LO = 2'd0,
    ADDR_LIMIT_HI = 2'd1,
    ADDR_IRQ_EN   = 2'd2
  } fcm_addr_e;
endpackage

// File: rtl/fcm_cfg_regs.sv
module fcm_cfg_regs
  import fcm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   limit,
  output logic [NUM_DIR-1:0] irq_en
);
  localparam int HI_W = CNT_W - REG_W;

  logic [REG_W-1:0] lim_lo_q;
  logic [HI_W-1:0]  lim_hi_q;
  logic [NUM_DIR-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_lo_q <= '0;
      lim_hi_q <= '0;
      en_q     <= '0;
    end else if (wr_en) begin
      case (fcm_addr_e'(wr_addr))
        ADDR_LIMIT_LO: lim_lo_q <= wr_data;
        ADDR_LIMIT_HI: lim_hi_q <= wr_data[HI_W-1:0];
        ADDR_IRQ_EN:   en_q     <= wr_data[NUM_DIR-1:0];
        default: ;
      endcase
    end
  end

  assign limit  = {lim_hi_q, lim_lo_q};
  assign irq_en = en_q;

  // R2: the upper limit part follows only the low data bits of its write
  p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> limit[CNT_W-1:REG_W] == $past(wr_data[HI_W-1:0]));
  // R2: writes to the enable register leave the limit untouched
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> $stable(limit));
endmodule

// File: rtl/fcm_byte_counter.sv
module fcm_byte_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfd,
  input  logic             byte_stb,
  input  logic             dir_tx,
  input  logic             tx_crc_phase,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             advance
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic in_frame_q;
  logic [CNT_W-1:0] count_q;
  logic crc_skip;

  assign crc_skip   = dir_tx && tx_crc_phase;
  assign advance    = byte_stb && in_frame_q && !sfd && !crc_skip;
  assign count_next = (count_q == CNT_MAX) ? count_q : count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      count_q    <= '0;
    end else if (sfd) begin
      in_frame_q <= 1'b1;
      count_q    <= '0;
    end else if (advance) begin
      count_q    <= count_next;
    end
  end

  assign count = count_q;

  // R3: a delimiter clears the count on the next cycle
  p_sfd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sfd |=> count == '0);
  // R4: a counted byte below saturation adds exactly one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1));
  // R5: transmit CRC bytes leave the count unchanged
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && crc_skip && !sfd) |=> $stable(count));
  // R6: saturated count stays at its maximum until a delimiter
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !sfd) |=> count == CNT_MAX);
endmodule

// File: rtl/fcm_irq_gen.sv
module fcm_irq_gen
  import fcm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sfd,
  input  logic               advance,
  input  logic [CNT_W-1:0]   count_next,
  input  logic [CNT_W-1:0]   limit,
  input  logic               dir_tx,
  input  logic [NUM_DIR-1:0] irq_en,
  output logic [NUM_DIR-1:0] irq
);
  logic used_q;
  logic match;
  logic [NUM_DIR-1:0] dir_sel;
  logic [NUM_DIR-1:0] irq_q;

  assign match = advance && !used_q && (count_next == limit);
  assign dir_sel[DIR_TX] = dir_tx;
  assign dir_sel[DIR_RX] = !dir_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used_q <= 1'b0;
    else if (sfd)    used_q <= 1'b0;
    else if (match)  used_q <= 1'b1;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[d] <= 1'b0;
      else        irq_q[d] <= match && dir_sel[d] && irq_en[d];
    end

    // R7: an interrupt only fires for an enabled direction
    p_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[d] |-> $past(irq_en[d]));
    // R8: never two pulses back to back
    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[d] |=> !irq_q[d]);
    // R9: a zero limit never produces a pulse
    p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[d] |-> $past(limit) != '0);
  end

  assign irq = irq_q;

  // R7: at most one direction signals at a time
  p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));
endmodule

// File: rtl/frame_count_monitor.sv
module frame_count_monitor
  import fcm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             sfd_seen,
  input  logic             byte_stb,
  input  logic             tx_crc_phase,
  input  logic             dir_tx,
  output logic [CNT_W-1:0] byte_count,
  output logic             irq_tx,
  output logic             irq_rx
);
  logic [CNT_W-1:0]   limit;
  logic [NUM_DIR-1:0] irq_en;
  logic [CNT_W-1:0]   count_next;
  logic               advance;
  logic [NUM_DIR-1:0] irq;

  fcm_cfg_regs #(.CNT_W(CNT_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wr_data), .limit(limit), .irq_en(irq_en)
  );

  fcm_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sfd(sfd_seen), .byte_stb(byte_stb),
    .dir_tx(dir_tx), .tx_crc_phase(tx_crc_phase), .count(byte_count),
    .count_next(count_next), .advance(advance)
  );

  fcm_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sfd(sfd_seen), .advance(advance),
    .count_next(count_next), .limit(limit), .dir_tx(dir_tx),
    .irq_en(irq_en), .irq(irq)
  );

  assign irq_tx = irq[DIR_TX];
  assign irq_rx = irq[DIR_RX];
endmodule

// File: tb/test_frame_count_monitor.sv
`timescale 1ns/1ps
module test_frame_count_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic sfd_seen = 1'b0;
  logic byte_stb = 1'b0;
  logic tx_crc_phase = 1'b0;
  logic dir_tx = 1'b0;
  logic [11:0] byte_count;
  logic irq_tx, irq_rx;

  int n_cmp = 0;
  int n_bad = 0;
  logic seen_tx, seen_rx;

  always #10 clk = ~clk;

  frame_count_monitor i_frame_count_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .sfd_seen(sfd_seen), .byte_stb(byte_stb),
    .tx_crc_phase(tx_crc_phase), .dir_tx(dir_tx), .byte_count(byte_count),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic sfd(input logic with_byte);
    sfd_seen = 1'b1; byte_stb = with_byte;
    @(negedge clk);
    sfd_seen = 1'b0; byte_stb = 1'b0;
  endtask

  task automatic send(input logic crc);
    byte_stb = 1'b1; tx_crc_phase = crc;
    @(negedge clk);
    byte_stb = 1'b0; tx_crc_phase = 1'b0;
    seen_tx = irq_tx; seen_rx = irq_rx;
  endtask

  task automatic t_reset;
    chk("R1 count", int'(byte_count), 0);
    chk("R1 irq", int'({irq_tx, irq_rx}), 0);
    send(1'b0);
    chk("R3 before first delimiter", int'(byte_count), 0);
  endtask

  task automatic t_rx_count;
    wr(2'd0, 8'd5); wr(2'd1, 8'hF0); wr(2'd2, 8'b10);
    dir_tx = 1'b0;
    sfd(1'b0);
    chk("R3 cleared", int'(byte_count), 0);
    for (int i = 1; i <= 7; i++) begin
      send(1'b0);
      chk("R4 count", int'(byte_count), i);
      chk("R7 R8 rx pulse", int'(seen_rx), (i == 5) ? 1 : 0);
      chk("R7 tx quiet", int'(seen_tx), 0);
    end
  endtask

  task automatic t_tx_crc;
    wr(2'd0, 8'd3); wr(2'd2, 8'b01);
    dir_tx = 1'b1;
    sfd(1'b0);
    send(1'b0); send(1'b0);
    send(1'b1); send(1'b1);
    chk("R5 crc excluded", int'(byte_count), 2);
    chk("R5 no pulse", int'(seen_tx), 0);
    send(1'b0);
    chk("R7 tx pulse", int'(seen_tx), 1);
    chk("R7 rx quiet", int'(seen_rx), 0);
    dir_tx = 1'b0;
    sfd(1'b0);
    send(1'b1);
    chk("R5 rx counts crc flag", int'(byte_count), 1);
  endtask

  task automatic t_masked;
    wr(2'd0, 8'd2); wr(2'd2, 8'b00);
    dir_tx = 1'b0;
    sfd(1'b0);
    send(1'b0); send(1'b0);
    chk("R7 masked", int'(seen_rx), 0);
    wr(2'd2, 8'b10);
    send(1'b0);
    chk("R8 used while masked", int'(seen_rx), 0);
    sfd(1'b1);
    chk("R3 strobe with delimiter", int'(byte_count), 0);
    send(1'b0); send(1'b0);
    chk("R8 re-armed", int'(seen_rx), 1);
  endtask

  task automatic t_zero_limit;
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'b11);
    sfd(1'b0);
    seen_tx = 1'b0; seen_rx = 1'b0;
    for (int i = 0; i < 4; i++) begin
      send(1'b0);
      chk("R9 zero limit", int'({seen_tx, seen_rx}), 0);
    end
  endtask

  task automatic t_high_limit;
    wr(2'd0, 8'h23); wr(2'd1, 8'hA1); wr(2'd2, 8'b10);
    dir_tx = 1'b0;
    sfd(1'b0);
    for (int i = 1; i <= 292; i++) begin
      send(1'b0);
      if (i >= 290) chk("R2 high nibble limit", int'(seen_rx), (i == 291) ? 1 : 0);
    end
  endtask

  task automatic t_saturate;
    int hits;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    sfd(1'b0);
    hits = 0;
    for (int i = 1; i < 4095; i++) begin
      send(1'b0);
      if (seen_rx) hits++;
    end
    chk("R7 no early pulse", hits, 0);
    send(1'b0);
    chk("R7 pulse at 4095", int'(seen_rx), 1);
    send(1'b0); send(1'b0);
    chk("R6 saturated", int'(byte_count), 4095);
    chk("R8 no repeat", int'(seen_rx), 0);
  endtask

  initial begin
    seen_tx = 1'b0; seen_rx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_count();
    t_tx_crc();
    t_masked();
    t_zero_limit();
    t_high_limit();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule